// File: doc/BRIEF.md
# Consecutive Overcurrent Fault Monitor

This block turns two digital current-limit indications into a fault decision for a boost converter with an output disconnect switch. The boost current-limit flag is looked at once per switching cycle, on a single-cycle strobe that arrives synchronous to the master clock. The disconnect-switch current-limit flag is looked at on every master clock cycle. Each flag has its own run counter. A run is broken by any sampled cycle without a hit, and the two runs have different lengths.

A run of boost hits raises the fault output but leaves the converter running. That fault goes away only when the converter is powered down, meaning the software enable bit is low. A run of disconnect-switch hits is a short to ground. It latches both the boost and the switch off, raises the fault output and sets a software-visible status bit. The latch is released by a power cycle (reset) or by software in a fixed order: first the enable bit goes to 0, then a fault-clear write is made. A clear write made while the enable bit is still 1 has no effect. Both counters are held at zero whenever the converter is not running (the enable bit is low or the latch is set), so every new run starts from zero.

Top module: `ocp_fault_monitor`

## Requirements
- R1: After reset, `fault_o`, `latch_off_o` and `fault_stat_o` are 0.
- R2: When `boost_ilim_i` is 1 on five switching-cycle strobes in a row while running, `fault_o` is 1 in the cycle after the clock edge that samples the fifth strobe. Four strobes in a row leave it at 0.
- R3: A strobe with `boost_ilim_i` at 0 restarts the boost run from zero. Cycles without a strobe neither advance nor restart the run, whatever `boost_ilim_i` is.
- R4: A boost fault never sets `latch_off_o` or `fault_stat_o`. It holds `fault_o` at 1 while `sw_en_i` stays 1, and `fault_o` returns to 0 one edge after `sw_en_i` is sampled at 0.
- R5: When `disc_ilim_i` is 1 on four master clock cycles in a row while running, `latch_off_o`, `fault_stat_o` and `fault_o` are all 1 after the fourth sampling edge. This happens without any switching strobe.
- R6: A cycle with `disc_ilim_i` at 0 restarts the disconnect run from zero.
- R7: A `fault_clr_wr_i` pulse that is sampled while `sw_en_i` is 1 leaves the latch, `latch_off_o` and `fault_stat_o` unchanged.
- R8: A `fault_clr_wr_i` pulse that is sampled while `sw_en_i` is 0 releases the latch. `latch_off_o`, `fault_stat_o` and `fault_o` are 0 after that edge.
- R9: While `sw_en_i` is 0 or the latch is set, limit hits do not count. After re-enabling, a full run of four hits is needed again.
- R10: Asserting `rst_n` low while latched clears all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| sw_cycle_stb_i | input | 1 | Single-cycle pulse, one per boost switching cycle |
| boost_ilim_i | input | 1 | Boost cycle-by-cycle current limit reached |
| disc_ilim_i | input | 1 | Disconnect-switch current limit reached |
| sw_en_i | input | 1 | Software enable bit for the converter |
| fault_clr_wr_i | input | 1 | Pulse: software writes 0 to the fault bit |
| fault_o | output | 1 | Fault flag, from either source |
| latch_off_o | output | 1 | Forces the boost and the disconnect switch off |
| fault_stat_o | output | 1 | Software-readable latched fault status bit |

## Verification
The bench tests the exact run lengths: four boost strobes must not trip and the fifth must, three switch hits must not latch and the fourth must. An off-by-one threshold would show up as an early or missing fault. It breaks runs with a single miss and adds non-strobe cycles that carry the opposite boost flag. A counter that does not restart, or one that samples outside the strobe, would then trip early. It tries the clear write in the wrong order and then in the right one, so a controller that ignores the enable bit would drop the latch too soon. It also interrupts a half-finished run by disabling the converter, which catches counters that keep stale counts across a re-enable.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Latch controller state
  typedef enum logic {
    LS_RUN     = 1'b0,
    LS_LATCHED = 1'b1
  } latch_state_e;

  // Counter width able to hold values 0..thr
  function automatic int run_cnt_w(input int thr);
    return (thr < 2) ? 1 : $clog2(thr + 1);
  endfunction

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ocp_hit_counter.sv
module ocp_hit_counter #(
  parameter int THRESH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sample_i,
  input  logic hit_i,
  output logic trip_o
);
  import ocp_pkg::*;

  localparam int CW = run_cnt_w(THRESH);
  localparam logic [CW-1:0] MAX_C  = CW'(THRESH);
  localparam logic [CW-1:0] LAST_C = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | sample_i;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (sample_i) begin
      if (!hit_i)            cnt_d = '0;
      else if (cnt_q != MAX_C) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip_o = !clr_i && sample_i && hit_i && (cnt_q == LAST_C);

  // R3 / R6: a sampled miss restarts the run
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !hit_i) |=> (cnt_q == '0));

  // R3: unsampled cycles leave the run untouched
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !clr_i) |=> $stable(cnt_q));

  // R9: not running forces the run back to zero
  p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R2 / R5: count never exceeds the threshold
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q <= MAX_C));

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en_i,
  input  logic clr_wr_i,
  input  logic disc_trip_i,
  input  logic boost_trip_i,
  output logic run_o,
  output logic latched_o,
  output logic boost_fault_o
);
  import ocp_pkg::*;

  latch_state_e state_q, state_d;
  logic         bfault_q, bfault_d;
  logic         clr_ok;

  assign clr_ok = clr_wr_i && !sw_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_RUN:     if (disc_trip_i) state_d = LS_LATCHED;
      LS_LATCHED: if (clr_ok)      state_d = LS_RUN;
      default:                     state_d = LS_RUN;
    endcase
  end

  always_comb begin
    bfault_d = bfault_q;
    if (!sw_en_i)          bfault_d = 1'b0;
    else if (boost_trip_i) bfault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_RUN;
      bfault_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bfault_q <= bfault_d;
    end
  end

  assign latched_o     = (state_q == LS_LATCHED);
  assign boost_fault_o = bfault_q;
  assign run_o         = sw_en_i && (state_q == LS_RUN);

  // R7: latch survives anything but an ordered clear
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !(clr_wr_i && !sw_en_i)) |=> latched_o);

  // R8: ordered clear releases the latch
  p_clear_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && clr_wr_i && !sw_en_i) |=> !latched_o);

  // R4: boost fault held while enabled
  p_bfault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_fault_o && sw_en_i) |=> boost_fault_o);

  // R4: powering down drops the boost fault
  p_bfault_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en_i |=> !boost_fault_o);

endmodule

// File: rtl/ocp_fault_monitor.sv
module ocp_fault_monitor #(
  parameter int BOOST_RUN   = 5,
  parameter int DISC_RUN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_cycle_stb_i,
  input  logic boost_ilim_i,
  input  logic disc_ilim_i,
  input  logic sw_en_i,
  input  logic fault_clr_wr_i,
  output logic fault_o,
  output logic latch_off_o,
  output logic fault_stat_o
);

  logic rst_n_s;
  logic run;
  logic boost_trip;
  logic disc_trip;
  logic latched;
  logic boost_fault;

  ocp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  // Boost run: advanced only by switching-cycle strobes
  ocp_hit_counter #(.THRESH(BOOST_RUN)) u_boost_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (!run),
    .sample_i (sw_cycle_stb_i),
    .hit_i    (boost_ilim_i),
    .trip_o   (boost_trip)
  );

  // Disconnect run: sampled every master clock, switching or not
  ocp_hit_counter #(.THRESH(DISC_RUN)) u_disc_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (!run),
    .sample_i (1'b1),
    .hit_i    (disc_ilim_i),
    .trip_o   (disc_trip)
  );

  ocp_fault_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .sw_en_i       (sw_en_i),
    .clr_wr_i      (fault_clr_wr_i),
    .disc_trip_i   (disc_trip),
    .boost_trip_i  (boost_trip),
    .run_o         (run),
    .latched_o     (latched),
    .boost_fault_o (boost_fault)
  );

  assign latch_off_o  = latched;
  assign fault_stat_o = latched;
  assign fault_o      = latched | boost_fault;

  // R5: latch only rises after a sampled switch hit while running
  p_latch_cause_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(latch_off_o) |-> $past(disc_ilim_i && sw_en_i));

  // R4: a boost-only run never latches the converter off
  p_boost_nolatch_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!latch_off_o && !disc_ilim_i) |=> !latch_off_o);

  // R1/R10: held reset means all outputs low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!fault_o && !latch_off_o && !fault_stat_o));

endmodule

// File: tb/ocp_fault_monitor_bench.sv
module ocp_fault_monitor_bench;

  logic clk = 1'b0;
  logic rst_n, stb, bil, dil, en, clr;
  logic fault, loff, stat;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  ocp_fault_monitor u_ocp_fault_monitor (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_cycle_stb_i (stb),
    .boost_ilim_i   (bil),
    .disc_ilim_i    (dil),
    .sw_en_i        (en),
    .fault_clr_wr_i (clr),
    .fault_o        (fault),
    .latch_off_o    (loff),
    .fault_stat_o   (stat)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stb = 0; bil = 0; dil = 0; en = 1; clr = 0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  // one switching cycle: strobe with hit, then two idle cycles carrying !hit
  task automatic bcycle(input logic hit);
    stb = 1; bil = hit; step();
    stb = 0; bil = !hit; step(2);
    bil = 0;
  endtask

  task automatic dhits(input int n);
    dil = 1; step(n); dil = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 fault", fault, 1'b0);
    chk("R1 latch", loff, 1'b0);
    chk("R1 stat", stat, 1'b0);
  endtask

  task automatic t_boost_run();
    do_reset();
    repeat (4) bcycle(1'b1);
    chk("R2 four strobes", fault, 1'b0);
    bcycle(1'b1);
    chk("R2 fifth strobe", fault, 1'b1);
    chk("R4 no latch", loff, 1'b0);
    chk("R4 no stat", stat, 1'b0);
    step(10);
    chk("R4 held", fault, 1'b1);
    en = 0; step();
    chk("R4 drop on power down", fault, 1'b0);
    en = 1; step();
  endtask

  task automatic t_boost_gap();
    do_reset();
    repeat (4) bcycle(1'b1);
    bcycle(1'b0);
    repeat (4) bcycle(1'b1);
    chk("R3 miss restarts run", fault, 1'b0);
    bcycle(1'b1);
    chk("R3 full run after miss", fault, 1'b1);
  endtask

  task automatic t_disc_run();
    do_reset();
    dil = 1; step(3);
    chk("R5 three hits", loff, 1'b0);
    step();
    chk("R5 latch", loff, 1'b1);
    chk("R5 stat", stat, 1'b1);
    chk("R5 fault", fault, 1'b1);
    dil = 0; step();
  endtask

  task automatic t_disc_gap();
    do_reset();
    dhits(3); step();
    dhits(3);
    chk("R6 gap restarts run", loff, 1'b0);
    dhits(1);
    chk("R6 latch after full run", loff, 1'b1);
  endtask

  task automatic t_clear_order();
    do_reset();
    dhits(4);
    clr = 1; step(); clr = 0; step();
    chk("R7 clear while enabled ignored", stat, 1'b1);
    chk("R7 latch kept", loff, 1'b1);
    en = 0; step();
    chk("R8 disabling alone keeps latch", loff, 1'b1);
    clr = 1; step(); clr = 0;
    chk("R8 latch released", loff, 1'b0);
    chk("R8 stat released", stat, 1'b0);
    chk("R8 fault released", fault, 1'b0);
    en = 1; step();
  endtask

  task automatic t_reenable();
    do_reset();
    en = 0; dil = 1; step(6);
    chk("R9 disabled hits ignored", loff, 1'b0);
    en = 1; step(3);
    dil = 0; step();
    en = 1; dil = 1; step(3);
    en = 0; step();
    en = 1; step();
    chk("R9 stale run discarded", loff, 1'b0);
    step(2);
    chk("R9 three fresh hits", loff, 1'b0);
    step();
    chk("R9 latch after fresh run", loff, 1'b1);
    dil = 0; step();
  endtask

  task automatic t_power_cycle();
    do_reset();
    dhits(4);
    chk("R10 latched before reset", loff, 1'b1);
    #1 rst_n = 1'b0; #0.5;
    chk("R10 async clear latch", loff, 1'b0);
    chk("R10 async clear fault", fault, 1'b0);
    step(); rst_n = 1'b1; step(4);
    chk("R10 stays clear", stat, 1'b0);
  endtask

  initial begin
    t_reset();
    t_boost_run();
    t_boost_gap();
    t_disc_run();
    t_disc_gap();
    t_clear_order();
    t_reenable();
    t_power_cycle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule